// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block keeps the tag and state side of a set-associative cache for a cache controller. It holds no data. For every way it stores a line address tag, an access permission and the context that owns a lock on the line. A least-recently-used replacement structure inside the block picks the victim way of each set.

The controller issues one operation per cycle on a command port. Each operation carries a line-aligned address, or a set and way, or a flat line index. The block answers one cycle later on registered response outputs: a hit/true flag, a way number and, for some operations, a line address. The operations are: permission-gated access check, presence lookup, availability check, allocation, deallocation, victim probe, recency touch, permission update, lock set, lock clear, lock test and readback by flat index. With the default parameters the directory has 16 sets of 4 ways over 64-byte lines in a 4 KiB cache.

Top module: `tag_directory`

## Requirements
- R1: The number of sets is CACHE_BYTES / WAYS / LINE_BYTES and must be at least two. The set is selected by the log2(sets) address bits starting at START_BIT (default: bit 6). Operation addresses are line aligned. Two addresses that differ only in their tag bits, or only in their set bits, are distinct lines.
- R2: A response appears exactly one cycle after each accepted operation, and rsp_valid is low after reset. rsp_hit is low whenever rsp_valid is low. Opcodes: 0 access, 1 present, 2 available, 3 allocate, 4 deallocate, 5 probe, 6 touch, 7 set permission, 8 lock set, 9 lock clear, 10 lock test, 11 readback.
- R3: Permission codes are 0 not-present, 1 invalid, 2 read-only, 3 read-write and 4 busy. A line counts as found only when an occupied way holds its tag and that way's permission is not 0. The present operation returns found.
- R4: Request types are 0 load, 1 instruction fetch and 2 store. An access hits for any type when the found way is read-write. It hits for load and fetch when the way is read-only. It misses in every other case.
- R5: An access that finds the line makes that way the most recent in its set, even when the permission denies the access.
- R6: The available operation returns true when a way of the set holds the address (whatever its permission), or when a way is empty or not-present.
- R7: Allocation fills the lowest-numbered way that is empty or not-present and returns that way with the hit flag set. It sets the permission to invalid (1) and the lock owner to all ones (no owner). It makes the way most recent only when op_touch is set.
- R8: Deallocation of a found line empties its way. The line is not found afterwards.
- R9: The probe returns the way, and the stored line address, of the least recently used way of the set. After reset the recency order of every set is way 0 newest to way WAYS-1 oldest. The touch operation makes the given set and way the most recent, with no tag search.
- R10: Lock set stores op_ctx as the owner of a found line, and lock clear stores all ones. Lock test is true only when the line is found and the stored owner equals op_ctx.
- R11: Readback of flat index i addresses set i / WAYS and way i mod WAYS. It returns the stored line address with the hit flag set, or address 0 with the flag clear when the way is empty, invalid or not-present.
- R12: The set-permission operation writes op_perm into the way that holds the address, whatever that way's current permission is, and reports whether such a way existed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation code (R2) |
| op_addr | input | ADDR_W | Line-aligned address |
| op_rtype | input | 2 | Request type for the access check |
| op_perm | input | 3 | Permission for the set-permission operation |
| op_touch | input | 1 | Make the allocated way most recent |
| op_ctx | input | CTX_W | Lock context |
| op_set | input | SET_W | Set for the touch operation |
| op_way | input | WAY_W | Way for the touch operation |
| op_index | input | IDX_W | Flat line index for readback |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Hit / true / done flag |
| rsp_way | output | WAY_W | Way concerned by the operation |
| rsp_addr | output | ADDR_W | Line address from probe or readback |

## Verification
The assertions check the properties that must hold on every cycle: one response per operation with no stray hit flag, line-aligned addresses, at most one way finding a line in the looked-up set, and exactly one oldest way in the recency order of that set. The bench's scenarios show the behaviours that need a history of operations. Those are the permission gating by request type, the recency update from a denied access, and the reuse of a not-present way by allocation. They also cover the victim that the touch flag does or does not move, lock ownership, and readback that hides invalid lines.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

  typedef enum logic [3:0] {
    OP_ACCESS   = 4'd0,
    OP_PRESENT  = 4'd1,
    OP_AVAIL    = 4'd2,
    OP_ALLOC    = 4'd3,
    OP_DEALLOC  = 4'd4,
    OP_PROBE    = 4'd5,
    OP_TOUCH    = 4'd6,
    OP_SET_PERM = 4'd7,
    OP_LOCK_SET = 4'd8,
    OP_LOCK_CLR = 4'd9,
    OP_LOCK_TST = 4'd10,
    OP_READ_IDX = 4'd11
  } tdir_op_e;

  typedef enum logic [2:0] {
    PERM_NP   = 3'd0,
    PERM_INV  = 3'd1,
    PERM_RO   = 3'd2,
    PERM_RW   = 3'd3,
    PERM_BUSY = 3'd4
  } tdir_perm_e;

  typedef enum logic [1:0] {
    REQ_LOAD  = 2'd0,
    REQ_FETCH = 2'd1,
    REQ_STORE = 2'd2
  } tdir_req_e;

  // Permission gate for the access check.
  function automatic logic perm_allows(input logic [2:0] p, input logic [1:0] r);
    return (p == PERM_RW) ||
           ((p == PERM_RO) && ((r == REQ_LOAD) || (r == REQ_FETCH)));
  endfunction

endpackage

// File: rtl/tdir_match.sv
// Parallel compare of all ways of one set; lowest way wins each encode.
module tdir_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][2:0]        way_perm,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic [WAYS-1:0]             found_vec,
  output logic [WAYS-1:0]             tagged_vec,
  output logic [WAYS-1:0]             free_vec,
  output logic [WAY_W-1:0]            found_way,
  output logic [WAY_W-1:0]            tagged_way,
  output logic [WAY_W-1:0]            free_way
);
  import tdir_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tagged_vec[w] = way_valid[w] && (way_tag[w] == cmp_tag);
    assign found_vec[w]  = tagged_vec[w] && (way_perm[w] != PERM_NP);
    assign free_vec[w]   = !way_valid[w] || (way_perm[w] == PERM_NP);
  end

  always_comb begin
    found_way  = '0;
    tagged_way = '0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (found_vec[w])  found_way  = WAY_W'(w);
      if (tagged_vec[w]) tagged_way = WAY_W'(w);
      if (free_vec[w])   free_way   = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tdir_lru.sv
// True LRU by per-way age counters: age 0 newest, age WAYS-1 oldest.
module tdir_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] rd_set,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way,
  output logic [WAYS-1:0]  victim_oh
);

  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] pivot;

  assign pivot = age_q[touch_set][touch_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < pivot)
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign victim_oh[w] = (age_q[rd_set][w] == WAY_W'(WAYS - 1));
  end

  always_comb begin
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (victim_oh[w]) victim_way = WAY_W'(w);
  end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
  import tdir_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_BYTES = 4096,
  parameter int WAYS        = 4,
  parameter int START_BIT   = $clog2(LINE_BYTES),
  parameter int CTX_W       = 4,
  localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS * WAYS),
  localparam int OFF_W = $clog2(LINE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [1:0]        op_rtype,
  input  logic [2:0]        op_perm,
  input  logic              op_touch,
  input  logic [CTX_W-1:0]  op_ctx,
  input  logic [SET_W-1:0]  op_set,
  input  logic [WAY_W-1:0]  op_way,
  input  logic [IDX_W-1:0]  op_index,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [CTX_W-1:0] LOCK_NONE = '1;

  if (SETS < 2 || (1 << SET_W) != SETS || (1 << WAY_W) != WAYS || WAYS < 2)
  begin : g_bad_geometry
    $error("tag_directory: sets and ways must be powers of two, sets >= 2");
  end

  // Way storage. Payload arrays carry no reset so they map to LUT RAM.
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [2:0]       perm_q  [SETS][WAYS];
  logic [CTX_W-1:0] lock_q  [SETS][WAYS];

  // Set selection.
  logic [SET_W-1:0] addr_set, idx_set, sel_set;
  logic [WAY_W-1:0] idx_way;
  logic [TAG_W-1:0] cmp_tag;

  assign addr_set = op_addr[START_BIT +: SET_W];
  assign cmp_tag  = op_addr[ADDR_W-1:OFF_W];
  assign idx_set  = op_index[IDX_W-1:WAY_W];
  assign idx_way  = op_index[WAY_W-1:0];

  always_comb begin
    case (op_code)
      OP_TOUCH:    sel_set = op_set;
      OP_READ_IDX: sel_set = idx_set;
      default:     sel_set = addr_set;
    endcase
  end

  // One set read out in parallel.
  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0][2:0]       set_perm;

  always_comb begin
    set_valid = valid_q[sel_set];
    for (int w = 0; w < WAYS; w++) begin
      set_tag[w]  = tag_q[sel_set][w];
      set_perm[w] = perm_q[sel_set][w];
    end
  end

  logic [WAYS-1:0]  m_found, m_tagged, m_free;
  logic [WAY_W-1:0] m_found_way, m_tagged_way, m_free_way;
  logic             any_found, any_tagged, any_free;

  tdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
    .way_valid  (set_valid),
    .way_tag    (set_tag),
    .way_perm   (set_perm),
    .cmp_tag    (cmp_tag),
    .found_vec  (m_found),
    .tagged_vec (m_tagged),
    .free_vec   (m_free),
    .found_way  (m_found_way),
    .tagged_way (m_tagged_way),
    .free_way   (m_free_way)
  );

  assign any_found  = |m_found;
  assign any_tagged = |m_tagged;
  assign any_free   = |m_free;

  // Replacement.
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic [WAY_W-1:0] lru_victim_way;
  logic [WAYS-1:0]  lru_victim_oh;

  tdir_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk        (clk),
    .rst        (rst),
    .rd_set     (sel_set),
    .touch_en   (touch_en),
    .touch_set  (sel_set),
    .touch_way  (touch_way),
    .victim_way (lru_victim_way),
    .victim_oh  (lru_victim_oh)
  );

  // Update decode.
  logic             alloc_en, dealloc_en, perm_en, lock_en;
  logic [CTX_W-1:0] lock_val;

  always_comb begin
    touch_en   = 1'b0;
    touch_way  = m_found_way;
    alloc_en   = 1'b0;
    dealloc_en = 1'b0;
    perm_en    = 1'b0;
    lock_en    = 1'b0;
    lock_val   = op_ctx;
    if (op_valid) begin
      case (op_code)
        OP_ACCESS:   touch_en = any_found;
        OP_ALLOC: begin
          alloc_en  = any_free;
          touch_en  = any_free && op_touch;
          touch_way = m_free_way;
        end
        OP_DEALLOC:  dealloc_en = any_found;
        OP_TOUCH: begin
          touch_en  = 1'b1;
          touch_way = op_way;
        end
        OP_SET_PERM: perm_en = any_tagged;
        OP_LOCK_SET: lock_en = any_found;
        OP_LOCK_CLR: begin
          lock_en  = any_found;
          lock_val = LOCK_NONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (alloc_en)   valid_q[sel_set][m_free_way]  <= 1'b1;
      if (dealloc_en) valid_q[sel_set][m_found_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[sel_set][m_free_way]  <= cmp_tag;
      perm_q[sel_set][m_free_way] <= PERM_INV;
      lock_q[sel_set][m_free_way] <= LOCK_NONE;
    end
    if (perm_en) perm_q[sel_set][m_tagged_way] <= op_perm;
    if (lock_en) lock_q[sel_set][m_found_way]  <= lock_val;
  end

  // Response.
  logic              nx_hit;
  logic [WAY_W-1:0]  nx_way;
  logic [ADDR_W-1:0] nx_addr;

  always_comb begin
    nx_hit  = 1'b0;
    nx_way  = m_found_way;
    nx_addr = '0;
    case (op_code)
      OP_ACCESS:   nx_hit = any_found && perm_allows(set_perm[m_found_way], op_rtype);
      OP_PRESENT:  nx_hit = any_found;
      OP_AVAIL:    nx_hit = any_tagged || any_free;
      OP_ALLOC: begin
        nx_hit = any_free;
        nx_way = m_free_way;
      end
      OP_DEALLOC:  nx_hit = any_found;
      OP_PROBE: begin
        nx_way  = lru_victim_way;
        nx_hit  = set_valid[lru_victim_way];
        nx_addr = nx_hit ? {set_tag[lru_victim_way], {OFF_W{1'b0}}} : '0;
      end
      OP_TOUCH: begin
        nx_hit = 1'b1;
        nx_way = op_way;
      end
      OP_SET_PERM: begin
        nx_hit = any_tagged;
        nx_way = m_tagged_way;
      end
      OP_LOCK_SET, OP_LOCK_CLR: nx_hit = any_found;
      OP_LOCK_TST: nx_hit = any_found && (lock_q[sel_set][m_found_way] == op_ctx);
      OP_READ_IDX: begin
        nx_way  = idx_way;
        nx_hit  = set_valid[idx_way] && (set_perm[idx_way] != PERM_NP) &&
                  (set_perm[idx_way] != PERM_INV);
        nx_addr = nx_hit ? {set_tag[idx_way], {OFF_W{1'b0}}} : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= op_valid;
      rsp_hit   <= op_valid && nx_hit;
      rsp_way   <= nx_way;
      rsp_addr  <= nx_addr;
    end
  end

endmodule

// File: rtl/tdir_chk.sv
module tdir_chk #(
  parameter int WAYS  = 4,
  parameter int OFF_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [OFF_W-1:0] addr_low,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [WAYS-1:0]  victim_oh,
  input logic [WAYS-1:0]  found_vec
);

  // R2
  rsp_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !rsp_valid);

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit);

  // R1
  line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (addr_low == '0));

  // R3
  single_found_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(found_vec));

  // R9
  one_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(victim_oh) == 1);

endmodule

bind tag_directory tdir_chk #(.WAYS(WAYS), .OFF_W(OFF_W)) i_tdir_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .addr_low  (op_addr[OFF_W-1:0]),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .victim_oh (lru_victim_oh),
  .found_vec (m_found)
);

// File: tb/test_tag_directory.sv
`timescale 1ns/1ps
module test_tag_directory;
  import tdir_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] op_addr = '0;
  logic [1:0]  op_rtype = '0;
  logic [2:0]  op_perm = '0;
  logic        op_touch = 1'b0;
  logic [3:0]  op_ctx = '0;
  logic [3:0]  op_set = '0;
  logic [1:0]  op_way = '0;
  logic [5:0]  op_index = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  tag_directory i_tag_directory (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_rtype(op_rtype), .op_perm(op_perm),
    .op_touch(op_touch), .op_ctx(op_ctx), .op_set(op_set), .op_way(op_way),
    .op_index(op_index), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_addr(rsp_addr)
  );

  // Line address: tag above bit 10, set in bits 9..6.
  function automatic logic [31:0] line(input int tag, input int set);
    return (32'(tag) << 10) | (32'(set) << 6);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Issue one operation; response is registered at the following edge.
  task automatic issue(input logic [3:0] c, input logic [31:0] a);
    @(negedge clk);
    op_code  = c;
    op_addr  = a;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    issue(OP_PRESENT, line(1, 1));
    check("R3 empty present", {31'd0, rsp_hit}, 32'd0);
    op_index = 6'd4;
    issue(OP_READ_IDX, '0);
    check("R11 empty readback", rsp_addr, 32'd0);
  endtask

  task automatic t_alloc;
    op_touch = 1'b0;
    issue(OP_ALLOC, line(1, 1));
    check("R7 alloc hit", {31'd0, rsp_hit}, 32'd1);
    check("R7 alloc way0", {30'd0, rsp_way}, 32'd0);
    issue(OP_PRESENT, line(1, 1));
    check("R3 present after alloc", {31'd0, rsp_hit}, 32'd1);
    op_rtype = REQ_LOAD;
    issue(OP_ACCESS, line(1, 1));
    check("R4 load on invalid", {31'd0, rsp_hit}, 32'd0);
    op_index = 6'd4;
    issue(OP_READ_IDX, '0);
    check("R11 invalid readback", rsp_addr, 32'd0);
  endtask

  task automatic t_perm;
    op_perm = PERM_RO;
    issue(OP_SET_PERM, line(1, 1));
    check("R12 set perm ro", {31'd0, rsp_hit}, 32'd1);
    op_rtype = REQ_LOAD;
    issue(OP_ACCESS, line(1, 1));
    check("R4 load on ro", {31'd0, rsp_hit}, 32'd1);
    op_rtype = REQ_FETCH;
    issue(OP_ACCESS, line(1, 1));
    check("R4 fetch on ro", {31'd0, rsp_hit}, 32'd1);
    op_rtype = REQ_STORE;
    issue(OP_ACCESS, line(1, 1));
    check("R4 store on ro", {31'd0, rsp_hit}, 32'd0);
    op_index = 6'd4;
    issue(OP_READ_IDX, '0);
    check("R11 ro readback", rsp_addr, line(1, 1));
    op_perm = PERM_RW;
    issue(OP_SET_PERM, line(1, 1));
    op_rtype = REQ_STORE;
    issue(OP_ACCESS, line(1, 1));
    check("R4 store on rw", {31'd0, rsp_hit}, 32'd1);
  endtask

  task automatic t_fill;
    op_touch = 1'b0;
    for (int t = 2; t <= 4; t++) begin
      issue(OP_ALLOC, line(t, 1));
      check("R7 fill way", {30'd0, rsp_way}, 32'(t - 1));
    end
    issue(OP_AVAIL, line(5, 1));
    check("R6 full set", {31'd0, rsp_hit}, 32'd0);
    issue(OP_AVAIL, line(1, 1));
    check("R6 held address", {31'd0, rsp_hit}, 32'd1);
    issue(OP_PROBE, line(5, 1));
    check("R9 reset victim way", {30'd0, rsp_way}, 32'd3);
    check("R9 reset victim addr", rsp_addr, line(4, 1));
  endtask

  task automatic t_lru;
    op_set = 4'd1;
    op_way = 2'd3;
    issue(OP_TOUCH, '0);
    issue(OP_PROBE, line(5, 1));
    check("R9 touch moves victim", rsp_addr, line(3, 1));
    op_rtype = REQ_STORE;
    issue(OP_ACCESS, line(1, 1));
    op_rtype = REQ_LOAD;
    issue(OP_ACCESS, line(3, 1));
    check("R4 load on invalid way2", {31'd0, rsp_hit}, 32'd0);
    issue(OP_PROBE, line(5, 1));
    check("R5 denied access touches", {30'd0, rsp_way}, 32'd1);
    check("R5 victim addr", rsp_addr, line(2, 1));
  endtask

  task automatic t_reuse;
    op_perm = PERM_NP;
    issue(OP_SET_PERM, line(2, 1));
    check("R12 set perm on invalid", {31'd0, rsp_hit}, 32'd1);
    issue(OP_PRESENT, line(2, 1));
    check("R3 not-present hidden", {31'd0, rsp_hit}, 32'd0);
    issue(OP_AVAIL, line(5, 1));
    check("R6 not-present free", {31'd0, rsp_hit}, 32'd1);
    op_touch = 1'b1;
    issue(OP_ALLOC, line(5, 1));
    check("R7 reuse not-present way", {30'd0, rsp_way}, 32'd1);
    issue(OP_PROBE, line(6, 1));
    check("R7 touch flag moves victim", {30'd0, rsp_way}, 32'd3);
    issue(OP_DEALLOC, line(4, 1));
    check("R8 dealloc hit", {31'd0, rsp_hit}, 32'd1);
    issue(OP_PRESENT, line(4, 1));
    check("R8 gone after dealloc", {31'd0, rsp_hit}, 32'd0);
    op_touch = 1'b0;
    issue(OP_ALLOC, line(6, 1));
    check("R7 alloc into emptied way", {30'd0, rsp_way}, 32'd3);
    issue(OP_PROBE, line(7, 1));
    check("R7 no touch keeps victim", rsp_addr, line(6, 1));
  endtask

  task automatic t_lock;
    op_ctx = 4'd5;
    issue(OP_LOCK_SET, line(1, 1));
    issue(OP_LOCK_TST, line(1, 1));
    check("R10 owner matches", {31'd0, rsp_hit}, 32'd1);
    op_ctx = 4'd3;
    issue(OP_LOCK_TST, line(1, 1));
    check("R10 other context", {31'd0, rsp_hit}, 32'd0);
    issue(OP_LOCK_CLR, line(1, 1));
    op_ctx = 4'd5;
    issue(OP_LOCK_TST, line(1, 1));
    check("R10 cleared", {31'd0, rsp_hit}, 32'd0);
    issue(OP_LOCK_TST, line(6, 1));
    check("R7 alloc lock not ctx5", {31'd0, rsp_hit}, 32'd0);
    op_ctx = 4'hF;
    issue(OP_LOCK_TST, line(6, 1));
    check("R7 alloc lock none", {31'd0, rsp_hit}, 32'd1);
  endtask

  task automatic t_index;
    op_perm = PERM_RW;
    issue(OP_SET_PERM, line(6, 1));
    op_index = 6'd7;
    issue(OP_READ_IDX, '0);
    check("R11 set1 way3", rsp_addr, line(6, 1));
    check("R11 way field", {30'd0, rsp_way}, 32'd3);
    op_index = 6'd8;
    issue(OP_READ_IDX, '0);
    check("R11 empty way", rsp_addr, 32'd0);
    op_perm = PERM_NP;
    issue(OP_SET_PERM, line(5, 1));
    op_index = 6'd5;
    issue(OP_READ_IDX, '0);
    check("R11 not-present readback", rsp_addr, 32'd0);
    op_index = 6'd4;
    issue(OP_READ_IDX, '0);
    check("R11 rw readback", rsp_addr, line(1, 1));
  endtask

  task automatic t_setidx;
    issue(OP_PRESENT, line(1, 2));
    check("R1 same tag other set", {31'd0, rsp_hit}, 32'd0);
    issue(OP_PRESENT, line(9, 1));
    check("R1 other tag same set", {31'd0, rsp_hit}, 32'd0);
    op_touch = 1'b0;
    issue(OP_ALLOC, line(1, 2));
    check("R1 independent set way0", {30'd0, rsp_way}, 32'd0);
    issue(OP_PRESENT, line(1, 1));
    check("R1 set1 line kept", {31'd0, rsp_hit}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_perm();
    t_fill();
    t_lru();
    t_reuse();
    t_lock();
    t_index();
    t_setidx();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule